// File: doc/BRIEF.md
# Masked Address Watchpoint Unit

This block is a debug comparator bank with two independent watchpoints. Each watchpoint watches the word address of instruction fetches and of data accesses. It raises a trap request when an access of an enabled type falls inside its watched region. The region is set by a base word address and a per-bit compare mask. Clearing low-order mask bits widens the match to any power-of-two aligned block of words.

Software programs each watchpoint through a small register port. Each watchpoint has two 32-bit registers. The first holds the base address and the fetch enable. The second holds the compare mask and the load and store enables. The trap request is combinational and appears in the same cycle as the access that causes it. The pipeline consumes the request together with a fixed trap number.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset every register reads zero, and no access raises `trap_req`.
- R2: `cfg_addr[1]` selects the watchpoint and `cfg_addr[0]` selects the register (0 for the address register, 1 for the mask register). A write with `cfg_we` high takes effect at the next rising clock edge. `cfg_rdata` shows the selected register combinationally.
- R3: The address register keeps bits 31:2 as the base word address and bit 0 as the fetch enable. Bit 1 of the address register always reads 0. The mask register keeps bits 31:2 as the compare mask, bit 1 as the load enable and bit 0 as the store enable.
- R4: An access matches a watchpoint when its word address (ports carry bits 31:2) equals the base on every bit whose mask bit is 1. Bits whose mask bit is 0 are ignored.
- R5: A fetch hits when `if_valid` is high, the fetch enable is set and the fetch address matches.
- R6: A data access with `dmem_write` low (a load) hits only when the load enable is set, `dmem_valid` is high and the address matches.
- R7: A data access with `dmem_write` high (a store) hits only when the store enable is set, `dmem_valid` is high and the address matches.
- R8: A watchpoint whose three enables are all clear never hits, whatever the mask or addresses.
- R9: `trap_req` is the OR of both watchpoints' hits. It is high in the same cycle as the qualifying access and low whenever neither valid strobe is high.
- R10: `trap_type` is 0x0B while `trap_req` is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: bit 1 selects the watchpoint, bit 0 selects the register (0 address, 1 mask) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| if_valid | input | 1 | Instruction fetch valid |
| if_addr | input | 30 | Fetch word address, bits 31:2 |
| dmem_valid | input | 1 | Data access valid |
| dmem_write | input | 1 | Data access is a store (1) or a load (0) |
| dmem_addr | input | 30 | Data word address, bits 31:2 |
| trap_req | output | 1 | Watchpoint trap request |
| trap_type | output | 8 | Trap number, 0x0B while requesting |

## Verification
The bench targets mask handling. It checks that addresses inside a cleared-mask region hit and addresses one region away miss. A design that compared unmasked bits would miss the in-range accesses, and one that ignored the mask would trap on the out-of-range ones. The bench also crosses access kinds with enables: a load to a watchpoint that has only the store enable, and a store to one that has only the load enable. A design that swapped the enable bits would trap on the wrong kind. Finally it drives matching addresses with the valid strobes low and with all enables cleared under a zero mask, so a design that failed to gate on valid or on the enables would raise a trap.

// File: rtl/addr_watch_unit.sv
module addr_watch_unit #(
  parameter int          NUM_WP   = 2,
  parameter logic [7:0]  TRAP_NUM = 8'h0B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        if_valid,
  input  logic [31:2] if_addr,
  input  logic        dmem_valid,
  input  logic        dmem_write,
  input  logic [31:2] dmem_addr,
  output logic        trap_req,
  output logic [7:0]  trap_type
);

  logic [31:2]       base_q  [NUM_WP];
  logic [31:2]       mask_q  [NUM_WP];
  logic [NUM_WP-1:0] fetch_en, load_en, store_en, hit;

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    logic sel, if_match, d_match, d_kind_ok;
    assign sel = (int'(cfg_addr[1]) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]   <= '0;
        mask_q[g]   <= '0;
        fetch_en[g] <= 1'b0;
        load_en[g]  <= 1'b0;
        store_en[g] <= 1'b0;
      end else if (cfg_we && sel) begin
        if (cfg_addr[0]) begin
          mask_q[g]   <= cfg_wdata[31:2];
          load_en[g]  <= cfg_wdata[1];
          store_en[g] <= cfg_wdata[0];
        end else begin
          base_q[g]   <= cfg_wdata[31:2];
          fetch_en[g] <= cfg_wdata[0];
        end
      end
    end

    assign if_match  = ((if_addr   ^ base_q[g]) & mask_q[g]) == '0;
    assign d_match   = ((dmem_addr ^ base_q[g]) & mask_q[g]) == '0;
    assign d_kind_ok = dmem_write ? store_en[g] : load_en[g];
    assign hit[g]    = (if_valid && fetch_en[g] && if_match) ||
                       (dmem_valid && d_kind_ok && d_match);

    p_disabled_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_en[g] || load_en[g] || store_en[g]) |-> !hit[g]);
    p_no_fetch_hit_without_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && !dmem_valid) |-> (fetch_en[g] && if_valid));
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_WP; i++) begin
      if (int'(cfg_addr[1]) == i)
        cfg_rdata = cfg_addr[0] ? {mask_q[i], load_en[i], store_en[i]}
                                : {base_q[i], 1'b0, fetch_en[i]};
    end
  end

  assign trap_req  = |hit;
  assign trap_type = trap_req ? TRAP_NUM : 8'h00;

  p_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (if_valid || dmem_valid));
  p_trap_number_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_type == 8'h0B));
  p_quiet_type_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> (trap_type == 8'h00));
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && cfg_addr == $past(cfg_addr) && !$past(cfg_addr[0]))
      |-> cfg_rdata == ($past(cfg_wdata) & 32'hFFFF_FFFD));
  p_mask_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && cfg_addr == $past(cfg_addr) && $past(cfg_addr[0]))
      |-> cfg_rdata == $past(cfg_wdata));

endmodule

// File: tb/addr_watch_unit_tb.sv
module addr_watch_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        if_valid = 0;
  logic [31:2] if_addr = 0;
  logic        dmem_valid = 0;
  logic        dmem_write = 0;
  logic [31:2] dmem_addr = 0;
  logic        trap_req;
  logic [7:0]  trap_type;

  int checks = 0, fails = 0;
  logic [31:0] m_reg [4];

  always #2 clk = ~clk;

  addr_watch_unit u_dut (.*);

  function automatic logic exp_trap();
    logic t = 0;
    for (int i = 0; i < 2; i++) begin
      logic [31:0] a = m_reg[2*i];
      logic [31:0] m = m_reg[2*i+1];
      if (if_valid && a[0] && (((if_addr ^ a[31:2]) & m[31:2]) == 0)) t = 1;
      if (dmem_valid && (dmem_write ? m[0] : m[1]) &&
          (((dmem_addr ^ a[31:2]) & m[31:2]) == 0)) t = 1;
    end
    return t;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] ca, input logic [31:0] wd,
                     input logic iv, input logic [31:0] ia,
                     input logic dv, input logic dw, input logic [31:0] da,
                     input string tag);
    cfg_we = we; cfg_addr = ca; cfg_wdata = wd;
    if_valid = iv; if_addr = ia[31:2];
    dmem_valid = dv; dmem_write = dw; dmem_addr = da[31:2];
    @(negedge clk);
    chk({tag, " trap_req"}, {31'b0, trap_req}, {31'b0, exp_trap()});
    chk("R10 trap_type", {24'b0, trap_type}, exp_trap() ? 32'h0B : 32'h0);
    chk({tag, " rdata"}, cfg_rdata, m_reg[ca]);
    @(posedge clk);
    if (we) m_reg[ca] = ca[0] ? wd : (wd & 32'hFFFF_FFFD);
    #1;
  endtask

  task automatic wr(input logic [1:0] ca, input logic [31:0] wd);
    cyc(1, ca, wd, 0, 0, 0, 0, 0, "R2 write");
  endtask

  task automatic rd(input logic [1:0] ca, input string tag);
    cyc(0, ca, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state, with accesses that would match a zero-mask watchpoint
    for (int i = 0; i < 4; i++) cyc(0, 2'(i), 0, 1, 32'h1234_5678, 1, i[0], 0, "R1");

    // R2 / R3 layout: bit 1 of address register drops
    wr(2'd0, 32'h4000_1003);
    rd(2'd0, "R3 addr bit1");
    wr(2'd1, 32'hFFFF_FFFC);
    rd(2'd1, "R2 mask readback");
    rd(2'd2, "R2 other wp untouched");

    // R5 fetch exact match, miss, and strobe low
    cyc(0, 0, 0, 1, 32'h4000_1000, 0, 0, 0, "R5 fetch hit");
    cyc(0, 0, 0, 1, 32'h4000_1002, 0, 0, 0, "R4 low bits not compared");
    cyc(0, 0, 0, 1, 32'h4000_1004, 0, 0, 0, "R4 next word miss");
    cyc(0, 0, 0, 0, 32'h4000_1000, 0, 0, 0, "R9 no valid");
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h4000_1000, "R6 load not enabled");

    // 4 KiB region with load enable
    wr(2'd1, 32'hFFFF_F002);
    cyc(0, 1, 0, 0, 0, 1, 0, 32'h4000_1FFC, "R4 range top load");
    cyc(0, 1, 0, 0, 0, 1, 0, 32'h4000_1000, "R6 load hit");
    cyc(0, 1, 0, 0, 0, 1, 0, 32'h4000_2000, "R4 outside range");
    cyc(0, 1, 0, 0, 0, 1, 1, 32'h4000_1800, "R7 store not enabled");
    cyc(0, 1, 0, 1, 32'h4000_1A00, 0, 0, 0, "R5 fetch in range");
    cyc(0, 1, 0, 0, 0, 0, 0, 32'h4000_1800, "R9 dmem_valid low");

    // wp1 store only
    wr(2'd2, 32'h8000_0000);
    wr(2'd3, 32'hFFFF_FFFD);
    rd(2'd3, "R3 mask store bit");
    cyc(0, 3, 0, 0, 0, 1, 1, 32'h8000_0000, "R7 store hit");
    cyc(0, 3, 0, 0, 0, 1, 0, 32'h8000_0000, "R6 load on store-only");
    cyc(0, 3, 0, 1, 32'h8000_0000, 0, 0, 0, "R5 fetch on store-only");

    // both simultaneously, and each alone
    cyc(0, 2, 0, 1, 32'h4000_1100, 1, 1, 32'h8000_0000, "R9 both hit");
    cyc(0, 2, 0, 1, 32'h9000_0000, 1, 1, 32'h8000_0000, "R9 wp1 alone");

    // R8 clear enables with zero mask
    wr(2'd0, 32'h4000_1000);
    wr(2'd1, 32'h0000_0000);
    wr(2'd2, 32'h0000_0000);
    wr(2'd3, 32'h0000_0000);
    cyc(0, 0, 0, 1, 32'h0ABC_0000, 1, 0, 32'h5555_0000, "R8 disabled load");
    cyc(0, 1, 0, 1, 32'hFFFF_FFFC, 1, 1, 32'h0000_0004, "R8 disabled store");
    // re-enable fetch only with zero mask: any address matches
    wr(2'd2, 32'h0000_0001);
    cyc(0, 2, 0, 1, 32'h7777_7774, 0, 0, 0, "R4 zero mask matches all");

    // R1 reset again clears
    rst_n = 0; #1;
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    @(posedge clk); #1 rst_n = 1;
    cyc(0, 2, 0, 1, 32'h7777_7774, 0, 0, 0, "R1 after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule